// File: doc/BRIEF.md
# Cycle-Count Memory Port to Avalon-MM Master Bridge

This block links a processor memory port to an Avalon-MM style master. The processor presents an address, write data and a read or write strobe for one clock cycle only, and then goes on executing. The bridge starts the bus transfer in that same cycle by passing the live address and data straight through. It also captures them, so that in any further cycles where the slave asserts waitrequest it can present the captured copies. Read and write stay asserted until the slave lets the transfer finish.

The processor does not get a one-bit acknowledge. It gets a two-bit ready count. The count reads 3 while the slave is still stalling and the remaining time is unknown. It reads 1 in the cycle the slave completes, and 0 when the bridge is idle or the result is already in the bridge. This lets a stalled processor pipeline restart a cycle early. Read data appears on the bus for one cycle only, so the bridge latches it and presents it to the processor until the next read completes. Only one transfer is in flight at a time.

Top module: `cycnt_avmm_bridge`

## Requirements
- R1: In the cycle a strobe arrives at an idle bridge, `bus_read` or `bus_write` is asserted and `bus_address` and `bus_writedata` equal the live processor inputs in that same cycle.
- R2: In every later cycle of a transfer while waitrequest is high, `bus_address` and `bus_writedata` keep the values captured in the first cycle, whatever the processor inputs do.
- R3: The bus read or write control stays asserted for as long as `bus_waitrequest` is high, and is low in the cycle after the slave completes (provided no new strobe arrives).
- R4: `cpu_ready_cnt` reads 3 in every cycle where a transfer is on the bus and `bus_waitrequest` is high.
- R5: `cpu_ready_cnt` reads 1 in the cycle where a transfer is on the bus and `bus_waitrequest` is low, which is the completing cycle.
- R6: `cpu_ready_cnt` reads 0 when no transfer is on the bus, including the cycle after a completion.
- R7: In the cycle after a read completes, `cpu_rdata` equals the `bus_readdata` value of the completing cycle. This value then holds through later writes and bus readdata changes until the next read completes.
- R8: Strobes that arrive while a transfer is pending are ignored: they start no second transfer and change neither the bus address nor the write data.
- R9: `bus_read` and `bus_write` are never high together. If both strobes arrive at once, the bridge issues a read.
- R10: A synchronous reset drops any pending transfer. After reset, both bus controls are low and `cpu_ready_cnt` is 0 while no strobe is applied.
- R11: A transfer with waitrequest low in its first cycle completes in that cycle. For a read, the data is available at the processor in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_addr | input | AW | Processor address, valid only in the strobe cycle |
| cpu_wdata | input | DW | Processor write data, valid only in the strobe cycle |
| cpu_rd | input | 1 | Single-cycle read strobe |
| cpu_wr | input | 1 | Single-cycle write strobe |
| cpu_rdata | output | DW | Latched read data, held until the next read completes |
| cpu_ready_cnt | output | 2 | Cycles-to-result count: 0 now or idle, 1 next cycle, 3 unknown |
| bus_address | output | AW | Master address |
| bus_writedata | output | DW | Master write data |
| bus_read | output | 1 | Master read control |
| bus_write | output | 1 | Master write control |
| bus_readdata | input | DW | Slave read data, valid in the completing cycle only |
| bus_waitrequest | input | 1 | Slave stall request |

## Verification
Reads and writes run against a slave model whose stall length varies from zero to several cycles. The zero-stall case separates the pass-through first cycle from the captured-copy path. The multi-cycle cases show whether the count moves 3, 1, 0 at the right cycles. During stalls the processor inputs are scrambled and extra strobes are applied, so a mux that selects the live value or a missing ignore rule shows up on the bus. Reads interleaved with writes, with the slave readdata changing meanwhile, show whether the read latch holds its value. Simultaneous strobes and a reset in the middle of a transfer test the exclusion and abort paths.

// File: rtl/cycnt_bridge_pkg.sv
package cycnt_bridge_pkg;

    // Ready count encoding seen by the processor
    typedef enum logic [1:0] {
        RDY_NOW     = 2'd0,
        RDY_NEXT    = 2'd1,
        RDY_UNKNOWN = 2'd3
    } rdy_cnt_e;

    // Transfer tracking state
    typedef struct packed {
        logic pend;    // transfer still stalled by the slave
        logic is_rd;   // kind of the pending transfer
    } xfer_state_t;

endpackage

// File: rtl/cycnt_xfer_ctl.sv
module cycnt_xfer_ctl
    import cycnt_bridge_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cpu_rd,
    input  logic cpu_wr,
    input  logic bus_wait,
    output logic first,
    output logic active,
    output logic done,
    output logic done_rd,
    output logic bus_rd,
    output logic bus_wr
);

    xfer_state_t st_d, st_q;
    logic        cur_rd;

    always_comb begin
        st_d   = st_q;
        first  = !rst && !st_q.pend && (cpu_rd || cpu_wr);
        cur_rd = st_q.pend ? st_q.is_rd : cpu_rd;   // read wins on a double strobe
        active = first || (st_q.pend && !rst);
        done   = active && !bus_wait;
        done_rd = done && cur_rd;
        bus_rd = active && cur_rd;
        bus_wr = active && !cur_rd;

        if (first && bus_wait) begin
            st_d.pend  = 1'b1;
            st_d.is_rd = cpu_rd;
        end
        if (st_q.pend && !bus_wait) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_rd_held_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_wait) |=> bus_rd);
    assert_wr_held_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_wait) |=> bus_wr);
    assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        (active && bus_wait) |=> !first);

endmodule

// File: rtl/cycnt_hold_mux.sv
module cycnt_hold_mux #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] live,
    output logic [W-1:0] bus_val
);

    logic [W-1:0] hold_d, hold_q;

    always_comb begin
        hold_d  = capture ? live : hold_q;
        bus_val = capture ? live : hold_q;   // first cycle is a pass-through
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

endmodule

// File: rtl/cycnt_rd_latch.sv
module cycnt_rd_latch #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] data_d, data_q;

    always_comb begin
        data_d = take ? din : data_q;
        dout   = data_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/cycnt_avmm_bridge.sv
module cycnt_avmm_bridge
    import cycnt_bridge_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    input  logic          cpu_rd,
    input  logic          cpu_wr,
    output logic [DW-1:0] cpu_rdata,
    output logic [1:0]    cpu_ready_cnt,
    output logic [AW-1:0] bus_address,
    output logic [DW-1:0] bus_writedata,
    output logic          bus_read,
    output logic          bus_write,
    input  logic [DW-1:0] bus_readdata,
    input  logic          bus_waitrequest
);

    localparam int HW = AW + DW;

    logic          first, active, done, done_rd;
    logic [HW-1:0] hold_out;
    rdy_cnt_e      rdy;

    cycnt_xfer_ctl i_ctl (
        .clk     (clk),
        .rst     (rst),
        .cpu_rd  (cpu_rd),
        .cpu_wr  (cpu_wr),
        .bus_wait(bus_waitrequest),
        .first   (first),
        .active  (active),
        .done    (done),
        .done_rd (done_rd),
        .bus_rd  (bus_read),
        .bus_wr  (bus_write)
    );

    cycnt_hold_mux #(.W(HW)) i_hold (
        .clk    (clk),
        .rst    (rst),
        .capture(first),
        .live   ({cpu_addr, cpu_wdata}),
        .bus_val(hold_out)
    );

    assign bus_address   = hold_out[HW-1:DW];
    assign bus_writedata = hold_out[DW-1:0];

    cycnt_rd_latch #(.DW(DW)) i_rdl (
        .clk (clk),
        .rst (rst),
        .take(done_rd),
        .din (bus_readdata),
        .dout(cpu_rdata)
    );

    always_comb begin
        if (!active)         rdy = RDY_NOW;
        else if (done)       rdy = RDY_NEXT;
        else                 rdy = RDY_UNKNOWN;
    end
    assign cpu_ready_cnt = rdy;

    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_read && bus_write));
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        ((bus_read || bus_write) && bus_waitrequest)
        |=> ($stable(bus_address) && $stable(bus_writedata)));
    assert_cnt_wait_R4: assert property (@(posedge clk) disable iff (rst)
        ((bus_read || bus_write) && bus_waitrequest) |-> (cpu_ready_cnt == 2'd3));
    assert_cnt_done_R5: assert property (@(posedge clk) disable iff (rst)
        ((bus_read || bus_write) && !bus_waitrequest) |-> (cpu_ready_cnt == 2'd1));
    assert_rdata_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_read && !bus_waitrequest) |=> (cpu_rdata == $past(bus_readdata)));

endmodule

// File: tb/test_cycnt_avmm_bridge.sv
module test_cycnt_avmm_bridge;

    localparam int AW = 24;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic [AW-1:0] cpu_addr;
    logic [DW-1:0] cpu_wdata;
    logic          cpu_rd, cpu_wr;
    logic [DW-1:0] cpu_rdata;
    logic [1:0]    cpu_ready_cnt;
    logic [AW-1:0] bus_address;
    logic [DW-1:0] bus_writedata;
    logic          bus_read, bus_write;
    logic [DW-1:0] bus_readdata;
    logic          bus_waitrequest;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;
    logic [DW-1:0] exp_q[$];
    logic [DW-1:0] last_rd;

    always #4 clk = ~clk;   // 125 MHz

    cycnt_avmm_bridge #(.AW(AW), .DW(DW)) i_cycnt_avmm_bridge (
        .clk(clk), .rst(rst),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_rdata(cpu_rdata), .cpu_ready_cnt(cpu_ready_cnt),
        .bus_address(bus_address), .bus_writedata(bus_writedata),
        .bus_read(bus_read), .bus_write(bus_write),
        .bus_readdata(bus_readdata), .bus_waitrequest(bus_waitrequest)
    );

    function automatic logic [DW-1:0] mem_f(input logic [AW-1:0] a);
        return {a[7:0], a} ^ 32'h5A3C_96E1;
    endfunction

    // Slave model: data valid only while not stalling
    always_comb bus_readdata = bus_waitrequest ? 32'hDEAD_BEEF : mem_f(bus_address);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: compares latched data after each read completion
    initial begin
        forever begin
            @(posedge clk);
            if (!rst && bus_read && !bus_waitrequest) begin
                #1;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7 unexpected read completion", 64'(cpu_rdata), 64'h0);
                end else begin
                    logic [DW-1:0] e;
                    e = exp_q.pop_front();
                    chk(cpu_rdata == e, "R7/R11 latched read data", 64'(cpu_rdata), 64'(e));
                    last_rd = e;
                end
            end
        end
    end

    task automatic xfer(input bit is_rd, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int waits, input bit both);
        @(negedge clk);
        cpu_rd = is_rd; cpu_wr = !is_rd || both;
        cpu_addr = a; cpu_wdata = d;
        bus_waitrequest = (waits > 0);
        if (is_rd) exp_q.push_back(mem_f(a));
        #2;
        chk(bus_read == is_rd && bus_write == !is_rd, "R1/R9 control in first cycle",
            64'({bus_read, bus_write}), 64'({is_rd, !is_rd}));
        chk(bus_address == a, "R1 live address", 64'(bus_address), 64'(a));
        if (!is_rd) chk(bus_writedata == d, "R1 live write data", 64'(bus_writedata), 64'(d));
        chk(cpu_ready_cnt == ((waits > 0) ? 2'd3 : 2'd1), "R4/R5/R11 count in first cycle",
            64'(cpu_ready_cnt), 64'((waits > 0) ? 3 : 1));
        for (int i = 1; i <= waits; i++) begin
            @(negedge clk);
            cpu_rd = (i == 2); cpu_wr = (i == 1);      // stray strobes, R8
            cpu_addr = ~a; cpu_wdata = ~d;
            bus_waitrequest = (i < waits);
            #2;
            chk(bus_read == is_rd && bus_write == !is_rd, "R3/R8 control held",
                64'({bus_read, bus_write}), 64'({is_rd, !is_rd}));
            chk(bus_address == a, "R2/R8 held address", 64'(bus_address), 64'(a));
            if (!is_rd) chk(bus_writedata == d, "R2 held write data", 64'(bus_writedata), 64'(d));
            chk(cpu_ready_cnt == ((i < waits) ? 2'd3 : 2'd1), "R4/R5 count during stall",
                64'(cpu_ready_cnt), 64'((i < waits) ? 3 : 1));
        end
        @(negedge clk);
        cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        bus_waitrequest = 1'b0;
        #2;
        chk(!bus_read && !bus_write, "R3 control dropped", 64'({bus_read, bus_write}), 64'h0);
        chk(cpu_ready_cnt == 2'd0, "R6 count after completion", 64'(cpu_ready_cnt), 64'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cpu_rd = 0; cpu_wr = 0; cpu_addr = '0; cpu_wdata = '0;
        bus_waitrequest = 1'b0; last_rd = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk(!bus_read && !bus_write && cpu_ready_cnt == 0, "R10 reset state",
            64'({bus_read, bus_write, cpu_ready_cnt}), 64'h0);
        chk(cpu_rdata == 0, "R10 reset read data", 64'(cpu_rdata), 64'h0);

        xfer(1'b1, 24'h000123, '0, 0, 1'b0);               // R11 zero stall read
        xfer(1'b1, 24'h00ABCD, '0, 1, 1'b0);
        xfer(1'b0, 24'h100040, 32'hCAFE_0001, 0, 1'b0);    // zero stall write
        chk(cpu_rdata == last_rd, "R7 data held over write", 64'(cpu_rdata), 64'(last_rd));
        xfer(1'b0, 24'h200080, 32'h1234_5678, 4, 1'b0);
        chk(cpu_rdata == last_rd, "R7 data held over stalled write", 64'(cpu_rdata), 64'(last_rd));
        xfer(1'b1, 24'h7FFFFF, '0, 5, 1'b0);
        xfer(1'b1, 24'h3C3C3C, '0, 2, 1'b1);               // R9 double strobe
        repeat (4) @(negedge clk);
        #2;
        chk(cpu_rdata == last_rd, "R7 data held while idle", 64'(cpu_rdata), 64'(last_rd));
        chk(cpu_ready_cnt == 0, "R6 idle count", 64'(cpu_ready_cnt), 64'h0);

        // R10: reset during a stalled read
        @(negedge clk);
        cpu_rd = 1'b1; cpu_addr = 24'h555555; bus_waitrequest = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #2;
        chk(!bus_read && !bus_write, "R10 reset aborts transfer",
            64'({bus_read, bus_write}), 64'h0);
        chk(cpu_ready_cnt == 0, "R10 count after reset", 64'(cpu_ready_cnt), 64'h0);
        @(negedge clk);
        bus_waitrequest = 1'b0;
        xfer(1'b1, 24'h0F0F0F, '0, 3, 1'b0);
        chk(exp_q.size() == 0, "R7 scoreboard drained", 64'(exp_q.size()), 64'h0);

        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule